// File: doc/BRIEF.md
# Swizzled Vector Register Add Unit

This block holds a file of wide vector registers. Each register is split into four independent 24-bit channels, called a, b, c and d. In one cycle the unit reads two source registers. Each source passes through its own lane selector, so every lane of a temporary vector can take any channel of that source. Channels may be repeated or left out. The two temporaries are added lane by lane, and a per-channel write mask then chooses which channels of the destination register take the new sums. Sums for unselected channels are dropped. Channels outside the mask keep their old contents.

A channel can hold a plain 24-bit integer or a signed fixed-point value with 1 sign bit, 7 integer bits and 16 fraction bits. Both formats use the same wrapping adder, because the fixed-point sum has the same bit pattern as the integer sum. A debug port can read any register at any time and can load a whole register. This is the only way to put starting values into the file.

Top module: `swz_vadd_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register to zero.
- R2: `dbg_data_o` shows register `dbg_idx_i` combinationally. When `dbg_we_i` is high at a rising edge, all 96 bits of register `dbg_idx_i` are loaded from `dbg_wdata_i`.
- R3: Channel k of a register occupies bits [24k+23:24k], with a=0, b=1, c=2, d=3. Lane i of a swizzled temporary takes the source channel named by swizzle bits [2i+1:2i].
- R4: A swizzle may name the same channel in several lanes (for example abab or bbaa), and each lane still gets the named channel.
- R5: Lane i of the result is lane i of the first temporary plus lane i of the second, as a 24-bit two's-complement add that wraps modulo 2^24. Fixed-point s7.16 operands give the correct fixed-point sum.
- R6: On a rising edge with `valid_i` high, destination channel i is written with lane i of the result only when `wmask_i[i]` is 1. Every other channel keeps its previous value.
- R7: A valid operation with `wmask_i` equal to 4'b0000 leaves the destination register unchanged.
- R8: While `valid_i` is low, no register changes, except through a debug load.
- R9: When a source is also the destination, the operation uses the register's value from before the edge.
- R10: When a debug load and a valid operation target the same register in the same cycle, the debug load wins and the whole register takes `dbg_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Perform the add and masked write this cycle |
| src0_idx_i | input | 5 | First source register index |
| src1_idx_i | input | 5 | Second source register index |
| dst_idx_i | input | 5 | Destination register index |
| swz0_i | input | 8 | Lane selector code for the first source |
| swz1_i | input | 8 | Lane selector code for the second source |
| wmask_i | input | 4 | Per-channel destination write enable |
| dbg_idx_i | input | 5 | Debug read/load register index |
| dbg_we_i | input | 1 | Debug full-register load strobe |
| dbg_wdata_i | input | 96 | Debug load data |
| dbg_data_o | output | 96 | Debug read data for register `dbg_idx_i` |

## Verification
The add is driven with several swizzle patterns. The identity pattern (dcba) shows the basic lane alignment. A reversed pattern shows that a lane can fetch a channel other than its own. Repeating patterns (abab, bbaa, aaaa, dddd) show that one channel can be fanned out to several lanes. Operands of all-ones and 0x800000 catch carries that cross a channel boundary or fail to wrap, and a negative-plus-positive fixed-point pair checks the shared adder. Masks of all ones, a single channel, two channels and zero show which sums are dropped. A self-referencing operation done twice tells a read of the old value apart from any feed-through, and a randomized stream compared against a behavioural model each cycle covers the remaining mixes.

// File: rtl/swz_pkg.sv
package swz_pkg;
   // Default geometry of the register file
   localparam int DEF_NUM_REGS = 32;
   localparam int DEF_LANES    = 4;
   localparam int DEF_CH_W     = 24;

   // Channel names as selector codes
   typedef enum logic [1:0] {
      CH_A = 2'd0,
      CH_B = 2'd1,
      CH_C = 2'd2,
      CH_D = 2'd3
   } chan_e;

   // Selector variants
   localparam int SEL_MUX   = 0;
   localparam int SEL_ANDOR = 1;
endpackage

// File: rtl/swz_regfile.sv
module swz_regfile #(
   parameter int NUM_REGS = swz_pkg::DEF_NUM_REGS,
   parameter int LANES    = swz_pkg::DEF_LANES,
   parameter int CH_W     = swz_pkg::DEF_CH_W,
   localparam int IDX_W   = $clog2(NUM_REGS),
   localparam int REG_W   = LANES * CH_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd0_idx,
   output logic [REG_W-1:0] rd0_data,
   input  logic [IDX_W-1:0] rd1_idx,
   output logic [REG_W-1:0] rd1_data,
   input  logic [IDX_W-1:0] dbg_idx,
   output logic [REG_W-1:0] dbg_data,
   input  logic             dbg_we,
   input  logic [REG_W-1:0] dbg_wdata,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [LANES-1:0] wr_mask,
   input  logic [REG_W-1:0] wr_data
);
   logic [REG_W-1:0] mem_q [NUM_REGS];

   // Combinational reads, values from before the coming edge
   assign rd0_data = mem_q[rd0_idx];
   assign rd1_data = mem_q[rd1_idx];
   assign dbg_data = mem_q[dbg_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= '0;
      end else if (dbg_we) begin
         // Debug load overrides any same-cycle execution write
         mem_q[dbg_idx] <= dbg_wdata;
         if (wr_en && (wr_idx != dbg_idx)) begin
            for (int l = 0; l < LANES; l++)
               if (wr_mask[l]) mem_q[wr_idx][l*CH_W +: CH_W] <= wr_data[l*CH_W +: CH_W];
         end
      end else if (wr_en) begin
         for (int l = 0; l < LANES; l++)
            if (wr_mask[l]) mem_q[wr_idx][l*CH_W +: CH_W] <= wr_data[l*CH_W +: CH_W];
      end
   end
endmodule

// File: rtl/swz_lane_select.sv
module swz_lane_select #(
   parameter int LANES     = swz_pkg::DEF_LANES,
   parameter int CH_W      = swz_pkg::DEF_CH_W,
   parameter int SEL_STYLE = swz_pkg::SEL_MUX,
   localparam int SEL_W    = $clog2(LANES),
   localparam int REG_W    = LANES * CH_W
) (
   input  logic [REG_W-1:0]       src,
   input  logic [LANES*SEL_W-1:0] swz,
   output logic [REG_W-1:0]       dst
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [SEL_W-1:0] code;
      assign code = swz[l*SEL_W +: SEL_W];

      if (SEL_STYLE == swz_pkg::SEL_ANDOR) begin : g_andor
         always_comb begin
            dst[l*CH_W +: CH_W] = '0;
            for (int c = 0; c < LANES; c++)
               dst[l*CH_W +: CH_W] = dst[l*CH_W +: CH_W] |
                  (src[c*CH_W +: CH_W] & {CH_W{code == SEL_W'(c)}});
         end
      end else begin : g_mux
         assign dst[l*CH_W +: CH_W] = src[int'(code)*CH_W +: CH_W];
      end
   end
endmodule

// File: rtl/swz_lane_adder.sv
module swz_lane_adder #(
   parameter int LANES  = swz_pkg::DEF_LANES,
   parameter int CH_W   = swz_pkg::DEF_CH_W,
   localparam int REG_W = LANES * CH_W
) (
   input  logic [REG_W-1:0] op_a,
   input  logic [REG_W-1:0] op_b,
   output logic [REG_W-1:0] sum
);
   // Independent per-lane adders: no carry crosses a channel boundary
   for (genvar l = 0; l < LANES; l++) begin : g_add
      assign sum[l*CH_W +: CH_W] = op_a[l*CH_W +: CH_W] + op_b[l*CH_W +: CH_W];
   end
endmodule

// File: rtl/swz_vadd_unit.sv
module swz_vadd_unit #(
   parameter int NUM_REGS  = swz_pkg::DEF_NUM_REGS,
   parameter int LANES     = swz_pkg::DEF_LANES,
   parameter int CH_W      = swz_pkg::DEF_CH_W,
   parameter int SEL_STYLE = swz_pkg::SEL_MUX,
   localparam int IDX_W    = $clog2(NUM_REGS),
   localparam int SEL_W    = $clog2(LANES),
   localparam int REG_W    = LANES * CH_W
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   valid_i,
   input  logic [IDX_W-1:0]       src0_idx_i,
   input  logic [IDX_W-1:0]       src1_idx_i,
   input  logic [IDX_W-1:0]       dst_idx_i,
   input  logic [LANES*SEL_W-1:0] swz0_i,
   input  logic [LANES*SEL_W-1:0] swz1_i,
   input  logic [LANES-1:0]       wmask_i,
   input  logic [IDX_W-1:0]       dbg_idx_i,
   input  logic                   dbg_we_i,
   input  logic [REG_W-1:0]       dbg_wdata_i,
   output logic [REG_W-1:0]       dbg_data_o
);
   // Elaboration-time parameter checks
   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (LANES < 2 || (1 << SEL_W) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (CH_W < 1) begin : g_bad_chw
      $error("CH_W must be positive");
   end
   if (SEL_STYLE != swz_pkg::SEL_MUX && SEL_STYLE != swz_pkg::SEL_ANDOR) begin : g_bad_style
      $error("SEL_STYLE not recognised");
   end

   logic [REG_W-1:0] rd0_w, rd1_w, tmp0_w, tmp1_w, sum_w;

   swz_regfile #(.NUM_REGS(NUM_REGS), .LANES(LANES), .CH_W(CH_W)) u_rf (
      .clk       (clk),
      .rst       (rst),
      .rd0_idx   (src0_idx_i),
      .rd0_data  (rd0_w),
      .rd1_idx   (src1_idx_i),
      .rd1_data  (rd1_w),
      .dbg_idx   (dbg_idx_i),
      .dbg_data  (dbg_data_o),
      .dbg_we    (dbg_we_i),
      .dbg_wdata (dbg_wdata_i),
      .wr_en     (valid_i),
      .wr_idx    (dst_idx_i),
      .wr_mask   (wmask_i),
      .wr_data   (sum_w)
   );

   swz_lane_select #(.LANES(LANES), .CH_W(CH_W), .SEL_STYLE(SEL_STYLE)) u_sel0 (
      .src (rd0_w),
      .swz (swz0_i),
      .dst (tmp0_w)
   );

   swz_lane_select #(.LANES(LANES), .CH_W(CH_W), .SEL_STYLE(SEL_STYLE)) u_sel1 (
      .src (rd1_w),
      .swz (swz1_i),
      .dst (tmp1_w)
   );

   swz_lane_adder #(.LANES(LANES), .CH_W(CH_W)) u_add (
      .op_a (tmp0_w),
      .op_b (tmp1_w),
      .sum  (sum_w)
   );
endmodule

// File: rtl/swz_vadd_chk.sv
module swz_vadd_chk #(
   parameter int NUM_REGS = swz_pkg::DEF_NUM_REGS,
   parameter int LANES    = swz_pkg::DEF_LANES,
   parameter int CH_W     = swz_pkg::DEF_CH_W,
   localparam int IDX_W   = $clog2(NUM_REGS),
   localparam int REG_W   = LANES * CH_W
) (
   input logic             clk,
   input logic             rst,
   input logic             valid_i,
   input logic [IDX_W-1:0] dst_idx_i,
   input logic [LANES-1:0] wmask_i,
   input logic [IDX_W-1:0] dbg_idx_i,
   input logic             dbg_we_i,
   input logic [REG_W-1:0] dbg_data_o,
   input logic [REG_W-1:0] sum
);
   // R1
   reset_zero_chk: assert property (@(posedge clk) rst |=> dbg_data_o == '0);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!valid_i && !dbg_we_i) |=>
         (dbg_idx_i != $past(dbg_idx_i)) || $stable(dbg_data_o));

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      // R6
      keep_lane_chk: assert property (@(posedge clk) disable iff (rst)
         (valid_i && !dbg_we_i && dbg_idx_i == dst_idx_i && !wmask_i[l]) |=>
            (dbg_idx_i != $past(dbg_idx_i)) ||
            (dbg_data_o[l*CH_W +: CH_W] == $past(dbg_data_o[l*CH_W +: CH_W])));

      // R6
      write_lane_chk: assert property (@(posedge clk) disable iff (rst)
         (valid_i && !dbg_we_i && dbg_idx_i == dst_idx_i && wmask_i[l]) |=>
            (dbg_idx_i != $past(dbg_idx_i)) ||
            (dbg_data_o[l*CH_W +: CH_W] == $past(sum[l*CH_W +: CH_W])));
   end
endmodule

bind swz_vadd_unit swz_vadd_chk #(.NUM_REGS(NUM_REGS), .LANES(LANES), .CH_W(CH_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .valid_i    (valid_i),
   .dst_idx_i  (dst_idx_i),
   .wmask_i    (wmask_i),
   .dbg_idx_i  (dbg_idx_i),
   .dbg_we_i   (dbg_we_i),
   .dbg_data_o (dbg_data_o),
   .sum        (sum_w)
);

// File: tb/swz_vadd_unit_tb.sv
module swz_vadd_unit_tb;
   localparam int NR = 32;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_i = 1'b0;
   logic [4:0]  src0_idx_i = '0, src1_idx_i = '0, dst_idx_i = '0, dbg_idx_i = '0;
   logic [7:0]  swz0_i = '0, swz1_i = '0;
   logic [3:0]  wmask_i = '0;
   logic        dbg_we_i = 1'b0;
   logic [95:0] dbg_wdata_i = '0;
   logic [95:0] dbg_data_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [95:0] model [NR];

   always #10 clk = ~clk;

   swz_vadd_unit u_dut (
      .clk(clk), .rst(rst), .valid_i(valid_i),
      .src0_idx_i(src0_idx_i), .src1_idx_i(src1_idx_i), .dst_idx_i(dst_idx_i),
      .swz0_i(swz0_i), .swz1_i(swz1_i), .wmask_i(wmask_i),
      .dbg_idx_i(dbg_idx_i), .dbg_we_i(dbg_we_i), .dbg_wdata_i(dbg_wdata_i),
      .dbg_data_o(dbg_data_o)
   );

   // Behavioural reference, updated at each rising edge
   always @(posedge clk) begin
      logic [95:0] nv;
      if (rst) begin
         for (int r = 0; r < NR; r++) model[r] = '0;
      end else begin
         if (valid_i) begin
            nv = model[dst_idx_i];
            for (int i = 0; i < 4; i++) begin
               int c0, c1;
               c0 = int'(swz0_i[2*i +: 2]);
               c1 = int'(swz1_i[2*i +: 2]);
               if (wmask_i[i])
                  nv[24*i +: 24] = model[src0_idx_i][24*c0 +: 24] + model[src1_idx_i][24*c1 +: 24];
            end
            model[dst_idx_i] = nv;
         end
         if (dbg_we_i) model[dbg_idx_i] = dbg_wdata_i;
      end
   end

   // Per-cycle comparison of the debug read port against the model (R2)
   always begin
      @(negedge clk);
      #1;
      if (!done) begin
         n_chk++;
         if (dbg_data_o !== model[dbg_idx_i]) begin
            n_fail++;
            $display("FAIL R2 per-cycle idx=%0d actual=%h expected=%h", dbg_idx_i, dbg_data_o, model[dbg_idx_i]);
         end
      end
   end

   task automatic expect_reg(input int idx, input logic [95:0] exp, input string tag);
      @(negedge clk);
      dbg_idx_i = 5'(idx);
      #2;
      n_chk++;
      if (dbg_data_o !== exp) begin
         n_fail++;
         $display("FAIL %s idx=%0d actual=%h expected=%h", tag, idx, dbg_data_o, exp);
      end
   endtask

   task automatic load(input int idx, input logic [95:0] d);
      @(negedge clk);
      dbg_we_i = 1'b1; dbg_idx_i = 5'(idx); dbg_wdata_i = d;
      @(negedge clk);
      dbg_we_i = 1'b0;
   endtask

   task automatic op(input int s0, input int s1, input int d,
                     input logic [7:0] z0, input logic [7:0] z1,
                     input logic [3:0] m, input logic v);
      @(negedge clk);
      valid_i = v; src0_idx_i = 5'(s0); src1_idx_i = 5'(s1); dst_idx_i = 5'(d);
      swz0_i = z0; swz1_i = z1; wmask_i = m; dbg_idx_i = 5'(d);
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: every register zero after reset
      for (int r = 0; r < NR; r++) expect_reg(r, '0, "R1");

      // R2: debug loads
      load(1, 96'h000004_000003_000002_000001);
      load(2, 96'h000040_000030_000020_000010);
      load(3, {4{24'hAAAAAA}});
      expect_reg(1, 96'h000004_000003_000002_000001, "R2");

      // R4/R6: R3.ab = R1.abab + R2.bbaa
      op(1, 2, 3, 8'h44, 8'h05, 4'b0011, 1'b1);
      expect_reg(3, 96'hAAAAAA_AAAAAA_000022_000021, "R4 R6");

      // R3: identity plus reversed selection
      op(1, 2, 4, 8'hE4, 8'h1B, 4'b1111, 1'b1);
      expect_reg(4, 96'h000014_000023_000032_000041, "R3");

      // R6: single lane c, dddd fan-out
      op(1, 2, 4, 8'hFF, 8'hFF, 4'b0100, 1'b1);
      expect_reg(4, 96'h000014_000044_000032_000041, "R6");

      // R5: wrap modulo 2^24, no carry between channels
      load(5, {4{24'hFFFFFF}});
      load(6, 96'h800000_800000_800000_000002);
      op(5, 6, 7, 8'hE4, 8'hE4, 4'b1111, 1'b1);
      expect_reg(7, 96'h7FFFFF_7FFFFF_7FFFFF_000001, "R5");

      // R5: s7.16 -1.5 + 2.25 = 0.75
      load(9, 96'h000000_000000_000000_FE8000);
      load(10, 96'h000000_000000_000000_024000);
      op(9, 10, 8, 8'h00, 8'h00, 4'b0001, 1'b1);
      expect_reg(8, 96'h000000_000000_000000_00C000, "R5");

      // R7: zero mask
      op(1, 2, 3, 8'hE4, 8'hE4, 4'b0000, 1'b1);
      expect_reg(3, 96'hAAAAAA_AAAAAA_000022_000021, "R7");

      // R8: valid low
      op(1, 2, 3, 8'hE4, 8'hE4, 4'b1111, 1'b0);
      expect_reg(3, 96'hAAAAAA_AAAAAA_000022_000021, "R8");

      // R9: source equals destination, twice
      load(11, 96'h000008_000007_000006_000005);
      op(11, 11, 11, 8'hE4, 8'hE4, 4'b1111, 1'b1);
      expect_reg(11, 96'h000010_00000E_00000C_00000A, "R9");
      op(11, 11, 11, 8'hE4, 8'hE4, 4'b1111, 1'b1);
      expect_reg(11, 96'h000020_00001C_000018_000014, "R9");

      // R10: debug load and execution write to the same register
      @(negedge clk);
      valid_i = 1'b1; src0_idx_i = 5'd1; src1_idx_i = 5'd2; dst_idx_i = 5'd12;
      swz0_i = 8'hE4; swz1_i = 8'hE4; wmask_i = 4'b1111;
      dbg_we_i = 1'b1; dbg_idx_i = 5'd12; dbg_wdata_i = 96'h123456_789ABC_DEF012_345678;
      @(negedge clk);
      valid_i = 1'b0; dbg_we_i = 1'b0;
      expect_reg(12, 96'h123456_789ABC_DEF012_345678, "R10");

      // Randomized stream, compared each cycle by the model (R2 R3 R5 R6)
      for (int r = 0; r < NR; r++) load(r, {$urandom, $urandom, $urandom});
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         valid_i = ($urandom_range(0, 3) != 0);
         src0_idx_i = 5'($urandom); src1_idx_i = 5'($urandom);
         dst_idx_i = 5'($urandom);
         swz0_i = 8'($urandom); swz1_i = 8'($urandom);
         wmask_i = 4'($urandom);
         dbg_we_i = ($urandom_range(0, 15) == 0);
         dbg_wdata_i = {$urandom, $urandom, $urandom};
         dbg_idx_i = ($urandom_range(0, 1) == 0) ? dst_idx_i : 5'($urandom);
      end
      @(negedge clk);
      valid_i = 1'b0; dbg_we_i = 1'b0;
      for (int r = 0; r < NR; r++) expect_reg(r, model[r], "R6 final");

      @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule